// File: doc/BRIEF.md
# Primed IQ DAC Stream Buffer

This block sits between a fast upstream word source, such as a DMA read port, and a DAC sample interface that shares its clock. Each incoming word packs one complex baseband sample: the upper half carries I and the lower half carries Q. Words are stored in an internal first-in first-out buffer. The upstream side is held off with a ready signal whenever that buffer is full.

The DAC side stays silent until the buffer has been primed with a programmable number of words. From then on it emits one sample per clock, I and Q alternating, so each stored word occupies two consecutive DAC cycles. A Q value of zero still gets its own slot, which keeps the alternation intact.

If the buffer runs dry while streaming, a sticky underflow flag is raised. The DAC side keeps its slot cadence but outputs zeros until the buffer is primed again. A synchronous clear flushes everything and returns the block to its waiting state.

Top module: `iq_prime_buffer`

## Requirements
- R1: Every emitted word appears as two samples on consecutive cycles. The first has `dac_phase`=0 and carries bits [2*SAMPLE_W-1:SAMPLE_W] (I). The second has `dac_phase`=1 and carries bits [SAMPLE_W-1:0] (Q).
- R2: `in_ready` is low exactly when the buffer holds DEPTH words or `clear` is high. A word is stored only on a cycle where `in_valid` and `in_ready` are both high, and the stored count never exceeds DEPTH.
- R3: `dac_valid` stays low while waiting. It rises on the clock edge at which the count held before that edge is at least `prime_count` and at least one. The I sample of the oldest word is presented in that same cycle.
- R4: Once streaming, `dac_valid` stays high and `dac_phase` toggles on every cycle until `clear` or reset.
- R5: Words leave in arrival order, with none lost or repeated. A word whose Q half is zero still produces its Q slot with sample value 0.
- R6: At an I slot with an empty buffer, `underflow` is set. That I slot and the following Q slot carry 0. `underflow` then stays high until `clear` or reset.
- R7: After an underflow, every slot carries 0 with `dac_valid` high. At an I slot where the count is at least `prime_count` and at least one, normal output resumes from the oldest stored word.
- R8: `clear` acts at the next clock edge. It empties the buffer, drops `underflow` and `dac_valid`, and returns to waiting for priming. A word offered while `clear` is high is not stored.
- R9: During and after reset, `dac_valid`, `dac_phase`, `dac_sample` and `underflow` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous flush and restart |
| prime_count | input | $clog2(DEPTH+1) | Words required before streaming starts |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | 2*SAMPLE_W | Packed word, I upper, Q lower |
| in_ready | output | 1 | Buffer can accept a word |
| dac_valid | output | 1 | DAC sample valid |
| dac_phase | output | 1 | 0 for I slot, 1 for Q slot |
| dac_sample | output | SAMPLE_W | Current DAC sample |
| underflow | output | 1 | Sticky buffer-empty-while-streaming flag |

## Verification
A corrupted read pointer or count shows within two cycles as a wrong sample in an I or Q slot, because each word's halves are compared with the bench's own queue. A wrong priming decision shows as `dac_valid` rising one or more cycles early or late. A slot-phase error breaks the I/Q alternation on the very next cycle. A missed or spurious underflow differs at the flag in the first I slot after the buffer drains. Comparing every port on every clock means no such fault can hide for more than one word's duration.

// File: rtl/iq_buf_pkg.sv
// Package: shared types for the primed IQ stream buffer.
// Assumes: nothing beyond being compiled before the modules that import it.
package iq_buf_pkg;

    // DAC-side sequencing states
    typedef enum logic [1:0] {
        SEQ_WAIT    = 2'd0,   // waiting for the priming threshold
        SEQ_RUN     = 2'd1,   // streaming stored words
        SEQ_STARVED = 2'd2    // buffer ran dry, emitting zeros
    } seq_state_t;

endpackage

// File: rtl/iq_word_fifo.sv
// Module: iq_word_fifo
// Single-clock word buffer with a combinational read port and an occupancy count.
// Assumes: the caller never writes when full nor reads when empty; flush wins over both.
module iq_word_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;

    // Storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (wr_en && !flush) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            case ({wr_en, rd_en})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Read port and flags
    always_comb begin
        rd_data = mem[rd_ptr];
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
    end
endmodule

// File: rtl/iq_dac_sequencer.sv
// Module: iq_dac_sequencer
// Gates DAC output on a priming threshold, splits each word into an I then a Q slot,
// detects underflow and emits zeros while starved.
// Assumes: word_in is the oldest stored word and is valid whenever fifo_empty is low.
module iq_dac_sequencer
    import iq_buf_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CW       = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic [2*SAMPLE_W-1:0] word_in,
    input  logic [CW-1:0]         fifo_count,
    input  logic                  fifo_empty,
    input  logic [CW-1:0]         prime_count,
    output logic                  pop,
    output logic                  dac_valid,
    output logic                  dac_phase,
    output logic [SAMPLE_W-1:0]   dac_sample,
    output logic                  underflow
);
    localparam logic [SAMPLE_W-1:0] ZERO = '0;

    seq_state_t          state, nxt_state;
    logic                q_slot, nxt_q_slot;
    logic [SAMPLE_W-1:0] q_hold, nxt_hold;
    logic                nxt_valid, nxt_phase, nxt_uf;
    logic [SAMPLE_W-1:0] nxt_sample;
    logic                primed;

    // Priming test on the occupancy held before this edge
    always_comb primed = !fifo_empty && (fifo_count >= prime_count);

    // Next-state, next-output and pop decision
    always_comb begin
        nxt_state  = state;
        nxt_q_slot = q_slot;
        nxt_hold   = q_hold;
        nxt_valid  = dac_valid;
        nxt_phase  = dac_phase;
        nxt_sample = dac_sample;
        nxt_uf     = underflow;
        pop        = 1'b0;
        if (clear) begin
            nxt_state  = SEQ_WAIT;
            nxt_q_slot = 1'b0;
            nxt_hold   = ZERO;
            nxt_valid  = 1'b0;
            nxt_phase  = 1'b0;
            nxt_sample = ZERO;
            nxt_uf     = 1'b0;
        end else if (state == SEQ_WAIT) begin
            nxt_valid  = 1'b0;
            nxt_phase  = 1'b0;
            nxt_sample = ZERO;
            if (primed) begin
                pop        = 1'b1;
                nxt_state  = SEQ_RUN;
                nxt_valid  = 1'b1;
                nxt_sample = word_in[2*SAMPLE_W-1:SAMPLE_W];
                nxt_hold   = word_in[SAMPLE_W-1:0];
                nxt_q_slot = 1'b1;
            end
        end else if (q_slot) begin
            nxt_valid  = 1'b1;
            nxt_phase  = 1'b1;
            nxt_sample = (state == SEQ_STARVED) ? ZERO : q_hold;
            nxt_q_slot = 1'b0;
        end else begin
            nxt_valid  = 1'b1;
            nxt_phase  = 1'b0;
            nxt_q_slot = 1'b1;
            if ((state == SEQ_RUN && !fifo_empty) || (state == SEQ_STARVED && primed)) begin
                pop        = 1'b1;
                nxt_state  = SEQ_RUN;
                nxt_sample = word_in[2*SAMPLE_W-1:SAMPLE_W];
                nxt_hold   = word_in[SAMPLE_W-1:0];
            end else begin
                nxt_sample = ZERO;
                if (state == SEQ_RUN) begin
                    nxt_state = SEQ_STARVED;
                    nxt_uf    = 1'b1;
                end
            end
        end
    end

    // State and registered output update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_WAIT;
            q_slot     <= 1'b0;
            q_hold     <= ZERO;
            dac_valid  <= 1'b0;
            dac_phase  <= 1'b0;
            dac_sample <= ZERO;
            underflow  <= 1'b0;
        end else begin
            state      <= nxt_state;
            q_slot     <= nxt_q_slot;
            q_hold     <= nxt_hold;
            dac_valid  <= nxt_valid;
            dac_phase  <= nxt_phase;
            dac_sample <= nxt_sample;
            underflow  <= nxt_uf;
        end
    end
endmodule

// File: rtl/iq_prime_buffer.sv
// Module: iq_prime_buffer (top)
// Buffers packed IQ words from an upstream source and streams them to a DAC as
// alternating I and Q samples once a priming threshold is met.
// Assumes: one clock for both sides; prime_count <= DEPTH and steady while waiting.
module iq_prime_buffer #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic [$clog2(DEPTH+1)-1:0]   prime_count,
    input  logic                         in_valid,
    input  logic [2*SAMPLE_W-1:0]        in_data,
    output logic                         in_ready,
    output logic                         dac_valid,
    output logic                         dac_phase,
    output logic [SAMPLE_W-1:0]          dac_sample,
    output logic                         underflow
);
    localparam int WORD_W = 2*SAMPLE_W;
    localparam int CW     = $clog2(DEPTH+1);

    logic              wr_en, pop, full, empty;
    logic [WORD_W-1:0] head_word;
    logic [CW-1:0]     fifo_count;

    // Upstream handshake: hold off when full or while clearing
    always_comb begin
        in_ready = !full && !clear;
        wr_en    = in_valid && in_ready;
    end

    iq_word_fifo #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (clear),
        .wr_en   (wr_en),
        .wr_data (in_data),
        .rd_en   (pop),
        .rd_data (head_word),
        .count   (fifo_count),
        .full    (full),
        .empty   (empty)
    );

    iq_dac_sequencer #(
        .SAMPLE_W (SAMPLE_W),
        .CW       (CW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .word_in     (head_word),
        .fifo_count  (fifo_count),
        .fifo_empty  (empty),
        .prime_count (prime_count),
        .pop         (pop),
        .dac_valid   (dac_valid),
        .dac_phase   (dac_phase),
        .dac_sample  (dac_sample),
        .underflow   (underflow)
    );
endmodule

// File: rtl/iq_prime_buffer_chk.sv
// Module: iq_prime_buffer_chk
// Temporal checks on the buffer's ports and occupancy, attached by bind.
// Assumes: bound into iq_prime_buffer, where fifo_count is visible.
module iq_prime_buffer_chk #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 256
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       clear,
    input logic [$clog2(DEPTH+1)-1:0] prime_count,
    input logic                       in_ready,
    input logic                       dac_valid,
    input logic                       dac_phase,
    input logic [SAMPLE_W-1:0]        dac_sample,
    input logic                       underflow,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
    localparam int CW = $clog2(DEPTH+1);

    // R2: a full buffer refuses words and never exceeds its depth
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == CW'(DEPTH)) |-> !in_ready);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R3: no start while the threshold is unmet or the buffer is empty
    assert_prime_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_valid && !clear && (fifo_count < prime_count || fifo_count == '0)) |=> !dac_valid);

    // R4: I slot is followed by Q slot and vice versa
    assert_i_then_q_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_valid && !dac_phase && !clear) |=> (dac_valid && dac_phase));
    assert_q_then_i_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_valid && dac_phase && !clear) |=> (dac_valid && !dac_phase));

    // R6: underflow sticks and its first slot is zero
    assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !clear) |=> underflow);
    assert_underflow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> (dac_sample == '0 && !dac_phase));

    // R8: clear empties, silences and drops the flag
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!dac_valid && !underflow && fifo_count == '0));
endmodule

bind iq_prime_buffer iq_prime_buffer_chk #(
    .SAMPLE_W (SAMPLE_W),
    .DEPTH    (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .prime_count (prime_count),
    .in_ready    (in_ready),
    .dac_valid   (dac_valid),
    .dac_phase   (dac_phase),
    .dac_sample  (dac_sample),
    .underflow   (underflow),
    .fifo_count  (fifo_count)
);

// File: tb/iq_prime_buffer_bench.sv
// Bench: behavioural queue model of the buffer, compared with every port on every clock.
module iq_prime_buffer_bench;
    localparam int D  = 16;
    localparam int SW = 16;
    localparam int CW = $clog2(D+1);

    logic              clk = 1'b0;
    logic              rst_n, clear, in_valid;
    logic [CW-1:0]     prime_count;
    logic [2*SW-1:0]   in_data;
    logic              in_ready, dac_valid, dac_phase, underflow;
    logic [SW-1:0]     dac_sample;

    always #4 clk = ~clk;

    iq_prime_buffer #(.SAMPLE_W(SW), .DEPTH(D)) u_iq_prime_buffer (
        .clk(clk), .rst_n(rst_n), .clear(clear), .prime_count(prime_count),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .dac_valid(dac_valid), .dac_phase(dac_phase), .dac_sample(dac_sample),
        .underflow(underflow)
    );

    int checks = 0;
    int errors = 0;
    string scen = "R1";

    // Reference state: 0 wait, 1 run, 2 starved
    logic [2*SW-1:0] mq[$];
    int        m_st = 0;
    bit        m_nq = 0;
    logic [SW-1:0] m_hold = '0;
    bit        e_valid = 0, e_phase = 0, e_uf = 0;
    logic [SW-1:0] e_samp = '0;
    int        word_idx = 0;

    function automatic logic [2*SW-1:0] pat(int k);
        logic [SW-1:0] hi, lo;
        hi = SW'(4096 + k*37);
        lo = (k % 3 == 0) ? '0 : SW'(32768 + k*11);
        return {hi, lo};
    endfunction

    // Reference model update at each clock edge
    always @(posedge clk) begin
        bit acc, primed;
        logic [2*SW-1:0] w;
        acc    = in_valid && !clear && (mq.size() < D);
        primed = (mq.size() > 0) && (mq.size() >= int'(prime_count));
        if (!rst_n || clear) begin
            mq.delete(); m_st = 0; m_nq = 0; m_hold = '0;
            e_valid = 0; e_phase = 0; e_samp = '0; e_uf = 0;
            acc = 0;
        end else if (m_st == 0) begin
            e_valid = 0; e_phase = 0; e_samp = '0;
            if (primed) begin
                w = mq.pop_front();
                e_valid = 1; e_samp = w[2*SW-1:SW]; m_hold = w[SW-1:0];
                m_st = 1; m_nq = 1;
            end
        end else if (m_nq) begin
            e_valid = 1; e_phase = 1; e_samp = (m_st == 2) ? '0 : m_hold; m_nq = 0;
        end else begin
            e_valid = 1; e_phase = 0; m_nq = 1;
            if ((m_st == 1 && mq.size() > 0) || (m_st == 2 && primed)) begin
                w = mq.pop_front();
                e_samp = w[2*SW-1:SW]; m_hold = w[SW-1:0]; m_st = 1;
            end else begin
                e_samp = '0;
                if (m_st == 1) begin m_st = 2; e_uf = 1; end
            end
        end
        if (acc) begin
            mq.push_back(in_data);
            word_idx++;
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: compare all ports away from the edge, then refresh input data
    task automatic step();
        @(negedge clk);
        check(in_ready == (!clear && mq.size() < D), "R2", "in_ready", in_ready, (!clear && mq.size() < D));
        check(dac_valid == e_valid, "R3", "dac_valid", dac_valid, e_valid);
        check(dac_phase == e_phase, "R4", "dac_phase", dac_phase, e_phase);
        check(dac_sample == e_samp, scen, "dac_sample", dac_sample, e_samp);
        check(underflow == e_uf, "R6", "underflow", underflow, e_uf);
        in_data = pat(word_idx);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic feed_until(int target);
        in_valid = 1'b1;
        while (word_idx < target) step();
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; clear = 1'b0; in_valid = 1'b0; prime_count = CW'(4); in_data = pat(0);
        repeat (3) @(negedge clk);
        // R9: reset values
        check(!dac_valid && !dac_phase && dac_sample == '0 && !underflow && in_ready,
              "R9", "reset outputs", {dac_valid, underflow, in_ready}, 3'b001);
        rst_n = 1'b1;
        run(2);

        // R5: ordered stream with zero Q halves, then drain into underflow (R6)
        scen = "R5";
        feed_until(10);
        run(30);
        check(underflow == 1'b1, "R6", "flag after drain", underflow, 1);

        // R7: starved until re-primed, then resumes
        scen = "R7";
        feed_until(12);
        run(8);
        check(dac_valid && dac_sample == '0, "R7", "zeros while starved", dac_sample, 0);
        feed_until(14);
        run(20);

        // R8: clear with a word offered
        scen = "R8";
        clear = 1'b1; in_valid = 1'b1;
        step();
        clear = 1'b0; in_valid = 1'b0;
        step();
        check(!dac_valid && !underflow, "R8", "after clear", {dac_valid, underflow}, 0);

        // R2: fill to depth with full threshold, keep pushing while streaming
        scen = "R1";
        prime_count = CW'(D);
        in_valid = 1'b1;
        run(40);
        in_valid = 1'b0;
        run(40);

        // R3: zero threshold still needs a stored word
        clear = 1'b1; step(); clear = 1'b0;
        prime_count = '0;
        run(4);
        check(!dac_valid, "R3", "no start when empty", dac_valid, 0);
        in_valid = 1'b1; step(); in_valid = 1'b0;
        run(6);

        // R8: clear in mid-stream with input active
        scen = "R8";
        clear = 1'b1; step(); clear = 1'b0;
        prime_count = CW'(3);
        in_valid = 1'b1; run(10);
        clear = 1'b1; run(2); clear = 1'b0;
        run(5); in_valid = 1'b0;
        run(20);

        // R1: gapped upstream with a mid threshold
        scen = "R1";
        clear = 1'b1; step(); clear = 1'b0;
        prime_count = CW'(6);
        for (int k = 0; k < 30; k++) begin
            in_valid = (k % 3 != 0);
            step();
        end
        in_valid = 1'b0;
        run(30);

        summary();
        $finish;
    end
endmodule